// File: doc/BRIEF.md
# Two-Priority Interrupt Control Register

This block holds the 8-bit interrupt control word of a small processor core. It also holds a companion per-source priority word. It turns both into a registered interrupt request and a high/low vector select. Three core sources feed it: a timer overflow, an external pin event and a port-change event. Each source has an enable bit and a flag bit. A summary request from a group of peripheral interrupts is a fourth input. Software loads either register with a write strobe, and hardware sets source flags with single-cycle pulses.

A mode input picks between two schemes. In the legacy scheme there is one global enable and every request goes to the high vector. In the two-priority scheme each core source is routed to the high or the low vector. The pin source is always high. The timer and port-change sources follow their priority bits, and a high request always beats a low one. The core signals interrupt entry and return-from-interrupt, and the block clears or restores the matching global enable.

The control word is laid out, MSB first, as: high global enable, peripheral/low global enable, timer enable, pin enable, port-change enable, timer flag, pin flag, port-change flag. Each enable sits three bits above its flag.

Top module: `irq_ctl_top`

## Requirements
- R1: After a synchronous reset, ctl_q and pri_q read 0x00, irq_req is 0, vec_hi is 1 and the block is in single-priority mode.
- R2: A control write (wr_ctl) loads all eight bits of wr_ctl_data into ctl_q on the next clock. A priority write (wr_pri) keeps only bit 2 (timer priority) and bit 0 (port-change priority), and every other bit of pri_q reads 0.
- R3: hw_flag_set bit 2, bit 1 and bit 0 set the timer flag (ctl bit 2), the pin flag (bit 1) and the port-change flag (bit 0) on the next clock. No other bit changes. If a control write happens in the same cycle, the flag is set on top of the written value.
- R4: In single-priority mode, irq_req one clock after the state is 1 exactly when bit 7 is set and either a source is pending (enable bit i+3 and flag bit i both set, i = 0..2) or bit 6 and periph_req are both set.
- R5: In single-priority mode, vec_hi is always 1.
- R6: In two-priority mode, irq_req is 0 whenever bit 7 is clear, whatever the other bits and periph_req are.
- R7: In two-priority mode with bit 7 set, a pending pin source, or a pending timer or port-change source whose priority bit is 1, gives irq_req=1 and vec_hi=1. This holds even when a low-priority source is pending at the same time.
- R8: In two-priority mode with bit 7 set and only low-priority sources pending, irq_req=1 and vec_hi=0. periph_req has no effect in this mode.
- R9: In two-priority mode, when no request is raised, vec_hi keeps its previous value.
- R10: On irq_entry, bit 7 is cleared if vec_hi is 1, otherwise bit 6 is cleared. Entry overrides a same-cycle write to those bits, and it overrides a same-cycle irq_return.
- R11: On irq_return in two-priority mode, bit 7 is set if it is clear, otherwise bit 6 is set. In single-priority mode only bit 7 is set.
- R12: The prio_en input (1 = two-priority) is registered and governs evaluation from the following clock on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prio_en | input | 1 | 1 selects two-priority mode |
| wr_ctl | input | 1 | Control word write strobe |
| wr_ctl_data | input | 8 | Control word write data |
| wr_pri | input | 1 | Priority word write strobe |
| wr_pri_data | input | 8 | Priority word write data |
| hw_flag_set | input | 3 | Hardware flag-set pulses (bit i sets flag bit i) |
| periph_req | input | 1 | Peripheral group summary request |
| irq_entry | input | 1 | Core is entering an interrupt handler |
| irq_return | input | 1 | Core is returning from an interrupt handler |
| ctl_q | output | 8 | Current control word |
| pri_q | output | 8 | Current priority word |
| irq_req | output | 1 | Registered interrupt request |
| vec_hi | output | 1 | Registered vector select, 1 = high vector |

## Verification
The assertions check several rules on every cycle. Hardware pulses always set their flag, and a plain write lands intact. Entry always clears the enable that matches the current vector, and return always leaves the high enable set. No request is raised without the high enable. The vector stays high in single-priority mode and holds in two-priority mode while the high enable is clear. Only the bench's scenarios can show the full priority decision: pin-always-high, high beating low, the peripheral summary being ignored in two-priority mode, the two outcomes of a return, and the one-clock lag of the mode input.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;

    localparam int REG_W      = 8;
    localparam int NUM_SRC    = 3;
    localparam int ENA_OFS    = 3;
    localparam int GIE_HI_BIT = 7;
    localparam int GIE_LO_BIT = 6;
    localparam int PIN_SRC    = 1;

    typedef logic [REG_W-1:0]   reg_t;
    typedef logic [NUM_SRC-1:0] src_t;

    typedef struct packed {
        logic req;
        logic vec_hi;
        logic vec_upd;
    } eval_t;

    // sources whose enable and flag are both set
    function automatic src_t pending(reg_t r);
        return r[ENA_OFS +: NUM_SRC] & r[NUM_SRC-1:0];
    endfunction

    // sources treated as high priority: pin always, others by their bit
    function automatic src_t hi_mask(reg_t pri);
        src_t m;
        m = pri[NUM_SRC-1:0];
        m[PIN_SRC] = 1'b1;
        return m;
    endfunction

    // bits of the priority word that are stored
    function automatic reg_t pri_keep_mask();
        reg_t m;
        m = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            m[i] = (i != PIN_SRC);
        end
        return m;
    endfunction

endpackage

// File: rtl/irq_ctl_regs.sv
module irq_ctl_regs
    import irq_ctl_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic wr_ctl,
    input  reg_t wr_ctl_data,
    input  logic wr_pri,
    input  reg_t wr_pri_data,
    input  src_t hw_flag_set,
    input  logic irq_entry,
    input  logic irq_return,
    input  logic mode_q,
    input  logic vec_hi_q,
    output reg_t ctl_q,
    output reg_t pri_q
);

    localparam reg_t PRI_KEEP = pri_keep_mask();

    reg_t ctl_nxt;
    reg_t pri_nxt;

    // order: software write, hardware flags, then entry or return
    always_comb begin
        ctl_nxt = wr_ctl ? wr_ctl_data : ctl_q;
        ctl_nxt[NUM_SRC-1:0] = ctl_nxt[NUM_SRC-1:0] | hw_flag_set;
        if (irq_entry) begin
            if (vec_hi_q) begin
                ctl_nxt[GIE_HI_BIT] = 1'b0;
            end else begin
                ctl_nxt[GIE_LO_BIT] = 1'b0;
            end
        end else if (irq_return) begin
            if (mode_q && ctl_nxt[GIE_HI_BIT]) begin
                ctl_nxt[GIE_LO_BIT] = 1'b1;
            end else begin
                ctl_nxt[GIE_HI_BIT] = 1'b1;
            end
        end
    end

    always_comb begin
        pri_nxt = wr_pri ? (wr_pri_data & PRI_KEEP) : pri_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
            pri_q <= '0;
        end else begin
            ctl_q <= ctl_nxt;
            pri_q <= pri_nxt;
        end
    end

    // R3: each hardware pulse leaves its flag set
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_flag_chk
        p_hw_flag_set_r3: assert property (@(posedge clk) disable iff (rst)
            hw_flag_set[g] |=> ctl_q[g]);
    end

    // R2: an undisturbed write lands intact
    p_write_loads_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_ctl && hw_flag_set == '0 && !irq_entry && !irq_return)
        |=> ctl_q == $past(wr_ctl_data));

    // R10: entry clears the enable matching the current vector
    p_entry_hi_r10: assert property (@(posedge clk) disable iff (rst)
        (irq_entry && vec_hi_q) |=> !ctl_q[GIE_HI_BIT]);
    p_entry_lo_r10: assert property (@(posedge clk) disable iff (rst)
        (irq_entry && !vec_hi_q) |=> !ctl_q[GIE_LO_BIT]);

    // R11: after a return the high enable is always set
    p_return_hi_r11: assert property (@(posedge clk) disable iff (rst)
        (irq_return && !irq_entry) |=> ctl_q[GIE_HI_BIT]);

endmodule

// File: rtl/irq_ctl_eval.sv
module irq_ctl_eval
    import irq_ctl_pkg::*;
(
    input  reg_t  ctl,
    input  reg_t  pri,
    input  logic  mode,
    input  logic  periph_req,
    output eval_t ev
);

    src_t pend;
    src_t pend_hi;
    src_t pend_lo;
    logic gie_hi;

    always_comb begin
        pend    = pending(ctl);
        pend_hi = pend & hi_mask(pri);
        pend_lo = pend & ~hi_mask(pri);
        gie_hi  = ctl[GIE_HI_BIT];
        if (!mode) begin
            ev.req     = gie_hi && ((|pend) || (ctl[GIE_LO_BIT] && periph_req));
            ev.vec_hi  = 1'b1;
            ev.vec_upd = 1'b1;
        end else begin
            ev.req     = gie_hi && ((|pend_hi) || (|pend_lo));
            ev.vec_hi  = |pend_hi;
            ev.vec_upd = gie_hi && ((|pend_hi) || (|pend_lo));
        end
    end

endmodule

// File: rtl/irq_ctl_out.sv
module irq_ctl_out
    import irq_ctl_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  prio_en,
    input  eval_t ev,
    output logic  mode_q,
    output logic  irq_req,
    output logic  vec_hi
);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= 1'b0;
            irq_req <= 1'b0;
            vec_hi  <= 1'b1;
        end else begin
            mode_q  <= prio_en;
            irq_req <= ev.req;
            if (ev.vec_upd) begin
                vec_hi <= ev.vec_hi;
            end
        end
    end

    // R5: single-priority mode always selects the high vector
    p_single_vec_hi_r5: assert property (@(posedge clk) disable iff (rst)
        !mode_q |=> vec_hi);

    // R12: the mode input is taken one clock later
    p_mode_follows_r12: assert property (@(posedge clk) disable iff (rst)
        prio_en |=> mode_q);

endmodule

// File: rtl/irq_ctl_top.sv
module irq_ctl_top
    import irq_ctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             prio_en,
    input  logic             wr_ctl,
    input  logic [7:0]       wr_ctl_data,
    input  logic             wr_pri,
    input  logic [7:0]       wr_pri_data,
    input  logic [2:0]       hw_flag_set,
    input  logic             periph_req,
    input  logic             irq_entry,
    input  logic             irq_return,
    output logic [7:0]       ctl_q,
    output logic [7:0]       pri_q,
    output logic             irq_req,
    output logic             vec_hi
);

    logic  mode_q;
    eval_t ev;

    irq_ctl_regs i_regs (
        .clk         (clk),
        .rst         (rst),
        .wr_ctl      (wr_ctl),
        .wr_ctl_data (wr_ctl_data),
        .wr_pri      (wr_pri),
        .wr_pri_data (wr_pri_data),
        .hw_flag_set (hw_flag_set),
        .irq_entry   (irq_entry),
        .irq_return  (irq_return),
        .mode_q      (mode_q),
        .vec_hi_q    (vec_hi),
        .ctl_q       (ctl_q),
        .pri_q       (pri_q)
    );

    irq_ctl_eval i_eval (
        .ctl        (ctl_q),
        .pri        (pri_q),
        .mode       (mode_q),
        .periph_req (periph_req),
        .ev         (ev)
    );

    irq_ctl_out i_out (
        .clk     (clk),
        .rst     (rst),
        .prio_en (prio_en),
        .ev      (ev),
        .mode_q  (mode_q),
        .irq_req (irq_req),
        .vec_hi  (vec_hi)
    );

    // R6: no request while the high enable is clear
    p_no_req_no_gie_r6: assert property (@(posedge clk) disable iff (rst)
        !ctl_q[GIE_HI_BIT] |=> !irq_req);

    // R4: peripheral summary raises a request in single-priority mode
    p_periph_single_r4: assert property (@(posedge clk) disable iff (rst)
        (!mode_q && ctl_q[GIE_HI_BIT] && ctl_q[GIE_LO_BIT] && periph_req) |=> irq_req);

    // R9: vector select holds while two-priority mode has no request
    p_vec_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (mode_q && !ctl_q[GIE_HI_BIT]) |=> $stable(vec_hi));

endmodule

// File: tb/test_irq_ctl_top.sv
`timescale 1ns/1ps
module test_irq_ctl_top;

    logic       clk = 1'b0;
    logic       rst;
    logic       prio_en;
    logic       wr_ctl;
    logic [7:0] wr_ctl_data;
    logic       wr_pri;
    logic [7:0] wr_pri_data;
    logic [2:0] hw_flag_set;
    logic       periph_req;
    logic       irq_entry;
    logic       irq_return;
    logic [7:0] ctl_q;
    logic [7:0] pri_q;
    logic       irq_req;
    logic       vec_hi;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    irq_ctl_top i_irq_ctl_top (
        .clk(clk), .rst(rst), .prio_en(prio_en),
        .wr_ctl(wr_ctl), .wr_ctl_data(wr_ctl_data),
        .wr_pri(wr_pri), .wr_pri_data(wr_pri_data),
        .hw_flag_set(hw_flag_set), .periph_req(periph_req),
        .irq_entry(irq_entry), .irq_return(irq_return),
        .ctl_q(ctl_q), .pri_q(pri_q), .irq_req(irq_req), .vec_hi(vec_hi)
    );

    // {mode, ctl, pri, periph, exp_req, exp_vec_hi}
    localparam int NV = 23;
    localparam logic [19:0] TV [NV] = '{
        {1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1},
        {1'b0, 8'hA4, 8'h00, 1'b0, 1'b1, 1'b1},
        {1'b0, 8'h24, 8'h00, 1'b0, 1'b0, 1'b1},
        {1'b0, 8'h90, 8'h00, 1'b0, 1'b0, 1'b1},
        {1'b0, 8'h92, 8'h00, 1'b0, 1'b1, 1'b1},
        {1'b0, 8'h89, 8'h00, 1'b0, 1'b1, 1'b1},
        {1'b0, 8'hC0, 8'h00, 1'b1, 1'b1, 1'b1},
        {1'b0, 8'hC0, 8'h00, 1'b0, 1'b0, 1'b1},
        {1'b0, 8'h80, 8'h00, 1'b1, 1'b0, 1'b1},
        {1'b0, 8'h2D, 8'h00, 1'b0, 1'b0, 1'b1},
        {1'b0, 8'h8C, 8'h00, 1'b0, 1'b0, 1'b1},
        {1'b1, 8'h24, 8'h00, 1'b0, 1'b0, 1'b1},
        {1'b1, 8'hA4, 8'h04, 1'b0, 1'b1, 1'b1},
        {1'b1, 8'hA4, 8'h00, 1'b0, 1'b1, 1'b0},
        {1'b1, 8'h80, 8'h00, 1'b0, 1'b0, 1'b0},
        {1'b1, 8'h92, 8'h00, 1'b0, 1'b1, 1'b1},
        {1'b1, 8'hAD, 8'h01, 1'b0, 1'b1, 1'b1},
        {1'b1, 8'h89, 8'h04, 1'b0, 1'b1, 1'b0},
        {1'b1, 8'hC0, 8'h00, 1'b1, 1'b0, 1'b0},
        {1'b1, 8'h49, 8'h00, 1'b0, 1'b0, 1'b0},
        {1'b1, 8'hB6, 8'h00, 1'b0, 1'b1, 1'b1},
        {1'b1, 8'h7F, 8'h05, 1'b0, 1'b0, 1'b1},
        {1'b0, 8'h7F, 8'h00, 1'b0, 1'b0, 1'b1}
    };

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", tag, got, exp);
        end
    endtask

    task automatic load(input logic mode, input logic [7:0] c, input logic [7:0] p);
        prio_en = mode;
        wr_ctl = 1'b1; wr_ctl_data = c;
        wr_pri = 1'b1; wr_pri_data = p;
        tick();
        wr_ctl = 1'b0; wr_pri = 1'b0;
        tick();
    endtask

    task automatic write_ctl(input logic [7:0] c);
        wr_ctl = 1'b1; wr_ctl_data = c;
        tick();
        wr_ctl = 1'b0;
    endtask

    initial begin
        rst = 1'b1; prio_en = 1'b0; wr_ctl = 1'b0; wr_ctl_data = '0;
        wr_pri = 1'b0; wr_pri_data = '0; hw_flag_set = '0; periph_req = 1'b0;
        irq_entry = 1'b0; irq_return = 1'b0;
        @(negedge clk); tick(); tick();
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1 ctl", ctl_q, 8'h00);
        check("R1 pri", pri_q, 8'h00);
        check("R1 req", {7'b0, irq_req}, 8'h00);
        check("R1 vec", {7'b0, vec_hi}, 8'h01);

        // vector table
        for (int i = 0; i < NV; i++) begin
            periph_req = TV[i][2];
            load(TV[i][19], TV[i][18:11], TV[i][10:3]);
            check("R2 ctl load", ctl_q, TV[i][18:11]);
            if (!TV[i][19]) begin
                check("R4 req", {7'b0, irq_req}, {7'b0, TV[i][1]});
                check("R5 vec", {7'b0, vec_hi}, {7'b0, TV[i][0]});
            end else begin
                check("R6 req", {7'b0, irq_req}, {7'b0, TV[i][1]});
                if (!TV[i][1])
                    check("R9 vec hold", {7'b0, vec_hi}, {7'b0, TV[i][0]});
                else if (TV[i][0])
                    check("R7 vec high", {7'b0, vec_hi}, 8'h01);
                else
                    check("R8 vec low", {7'b0, vec_hi}, 8'h00);
            end
        end
        periph_req = 1'b0;

        // R2 priority write masking
        wr_pri = 1'b1; wr_pri_data = 8'hFF; tick(); wr_pri = 1'b0;
        check("R2 pri mask", pri_q, 8'h05);

        // R3 hardware flag pulses
        prio_en = 1'b0;
        write_ctl(8'h00);
        hw_flag_set = 3'b100; tick();
        check("R3 timer flag", ctl_q, 8'h04);
        hw_flag_set = 3'b010; tick();
        check("R3 pin flag", ctl_q, 8'h06);
        hw_flag_set = 3'b001; tick();
        check("R3 chg flag", ctl_q, 8'h07);
        hw_flag_set = 3'b010; wr_ctl = 1'b1; wr_ctl_data = 8'h80; tick();
        wr_ctl = 1'b0; hw_flag_set = 3'b000;
        check("R3 flag over write", ctl_q, 8'h82);

        // R10 entry in single mode clears bit 7
        write_ctl(8'hC0); tick();
        irq_entry = 1'b1; tick(); irq_entry = 1'b0;
        check("R10 entry single", ctl_q, 8'h40);

        // R10 entry and return together: entry wins
        write_ctl(8'h80); tick();
        irq_entry = 1'b1; irq_return = 1'b1; tick();
        irq_entry = 1'b0; irq_return = 1'b0;
        check("R10 entry over return", ctl_q, 8'h00);

        // R11 return in single mode
        write_ctl(8'h24);
        irq_return = 1'b1; tick(); irq_return = 1'b0;
        check("R11 return single clear", ctl_q, 8'hA4);
        write_ctl(8'hA0);
        irq_return = 1'b1; tick(); irq_return = 1'b0;
        check("R11 return single set", ctl_q, 8'hA0);

        // R10 entry, two-priority, low vector clears bit 6
        load(1'b1, 8'hE4, 8'h00);
        check("R8 low vec", {7'b0, vec_hi}, 8'h00);
        irq_entry = 1'b1; tick(); irq_entry = 1'b0;
        check("R10 entry low", ctl_q, 8'hA4);

        // R11 return, two-priority, bit 7 set -> set bit 6
        irq_return = 1'b1; tick(); irq_return = 1'b0;
        check("R11 return prio low", ctl_q, 8'hE4);

        // R12 mode change takes one extra clock
        prio_en = 1'b0; tick();
        check("R12 mode lag", {7'b0, vec_hi}, 8'h00);
        tick();
        check("R12 mode applied", {7'b0, vec_hi}, 8'h01);

        // R10 entry, two-priority, high vector clears bit 7
        load(1'b1, 8'hE4, 8'h04);
        check("R7 high vec", {7'b0, vec_hi}, 8'h01);
        irq_entry = 1'b1; tick(); irq_entry = 1'b0;
        check("R10 entry high", ctl_q, 8'h64);

        // R11 return, two-priority, bit 7 clear -> set bit 7
        irq_return = 1'b1; tick(); irq_return = 1'b0;
        check("R11 return prio high", ctl_q, 8'hE4);

        // R8 periph ignored in two-priority mode
        periph_req = 1'b1;
        load(1'b1, 8'hC0, 8'h00);
        check("R8 periph ignored", {7'b0, irq_req}, 8'h00);
        periph_req = 1'b0;

        // R1 reset clears again
        rst = 1'b1; tick(); rst = 1'b0; @(negedge clk);
        check("R1 reset ctl", ctl_q, 8'h00);
        check("R1 reset vec", {7'b0, vec_hi}, 8'h01);

        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

endmodule